// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a small three-wire serial nonvolatile memory in synthesizable logic. A host selects the device, clocks command frames in bit by bit, and reads words back on a separate data-out line. The storage is a word-organised array held in an inferred RAM. Commands cover single-word read and write, a fill of the whole array with one word, and a pair of commands that arm and disarm writing through a protect latch. All pins are sampled by a fast system clock. Serial clock rising edges are found by edge detection, so the serial clock must run well below the system clock.

A write is committed on one exact serial clock edge: the one that carries the last data bit. If select drops before that edge, the command is dropped and the array is left untouched. From that edge on, the internal programming period runs for a parameterised number of system clock cycles and nothing can stop it. New frames are ignored while it runs. During that time the data-out line reports busy when the device is selected, and it reports ready once programming has finished.

Top module: `eep3w_slave`

## Requirements
- R1: A frame is a 1 start bit, a 2-bit opcode, an 8-bit address (MSB first) and a 16-bit data word (MSB first), for 27 bits in all. Every bit is sampled on a serial clock rising edge while select is high. Low bits seen before the start bit are skipped.
- R2: After reset the protect latch is clear. While it is clear, write and fill frames leave the array unchanged.
- R3: Opcode 00 with address bits [7:6] = 11 sets the latch, and 00 with [7:6] = 00 clears it. Either takes effect only when all 11 header bits (start, opcode, address) have been clocked in.
- R4: Read (opcode 10) works with the latch set or clear. After the 11th rising edge, data-out gives one dummy 0 bit. After each later rising edge it gives the next word bit, MSB first.
- R5: Write (opcode 01) with the latch set stores the data word at the address. The store happens on the 27th rising edge.
- R6: If select drops before the 27th rising edge of a write, the array is left unchanged.
- R7: Once the 27th rising edge of an accepted write has occurred, the write completes even if select drops immediately.
- R8: Fill (opcode 00 with address bits [7:6] = 01), with the latch set, stores the data word at every address.
- R9: Dropping select cancels a read at any point. The next frame then works normally.
- R10: Frames that start while programming is busy are ignored, including writes.
- R11: After a commit, while select is high, data-out is 0 for BUSY_CYCLES system clocks and is 1 after that.
- R12: The latch stays set across commits. A second write with no new set command is stored.
- R13: The output enable follows select through two register stages, and data-out is 0 whenever the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for data-out; low means high impedance |

## Verification
A wrong bit counter or a misplaced header latch shows up at the ports within a single frame. A read then returns a shifted or wrong word, or the dummy bit is missing right after the 11th edge. A protect latch in the wrong state does not show until the next read, as a word that changed when it should not have, or one that failed to change. A busy timer or commit edge that is off shows as the ready flag on data-out rising at the wrong time. It can also show as a cancelled write that still landed, or a write during busy that was taken.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  localparam logic [1:0] SUB_WDIS = 2'b00;
  localparam logic [1:0] SUB_FILL = 2'b01;
  localparam logic [1:0] SUB_WEN  = 2'b11;
endpackage

// File: rtl/eep3w_frame_rx.sv
module eep3w_frame_rx
  import eep3w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              sdi,
  input  logic              enable,
  output logic              wen,
  output logic              rd_go,
  output logic              commit,
  output logic              commit_all,
  output logic [ADDR_W-1:0] addr_now,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] word_now
);
  localparam int HDR_LEN   = 3 + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int SH_W      = (ADDR_W + 1 > DATA_W - 1) ? ADDR_W + 1 : DATA_W - 1;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;
  op_e              op_now, op_q;
  logic             step, at_hdr, at_end, is_fill;

  assign step     = sel && rise && enable;
  assign at_hdr   = step && (cnt == CNT_W'(HDR_LEN - 1));
  assign at_end   = step && (cnt == CNT_W'(FRAME_LEN - 1));
  assign op_now   = op_e'(sh[ADDR_W:ADDR_W-1]);
  assign addr_now = {sh[ADDR_W-2:0], sdi};
  assign word_now = {sh[DATA_W-2:0], sdi};
  assign is_fill  = (op_q == OP_EXT) && (op_addr[ADDR_W-1:ADDR_W-2] == SUB_FILL);

  assign rd_go      = at_hdr && (op_now == OP_READ);
  assign commit     = at_end && wen && ((op_q == OP_WRITE) || is_fill);
  assign commit_all = is_fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sh      <= '0;
      wen     <= 1'b0;
      op_q    <= OP_RSVD;
      op_addr <= '0;
    end else if (!sel) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt == '0) begin
        if (sdi) cnt <= CNT_W'(1);
      end else if (cnt != CNT_W'(FRAME_LEN)) begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[SH_W-2:0], sdi};
      end
      if (at_hdr) begin
        op_q    <= op_now;
        op_addr <= addr_now;
        if (op_now == OP_EXT) begin
          if (addr_now[ADDR_W-1:ADDR_W-2] == SUB_WEN)  wen <= 1'b1;
          if (addr_now[ADDR_W-1:ADDR_W-2] == SUB_WDIS) wen <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eep3w_store.sv
module eep3w_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep3w_prog.sv
module eep3w_prog #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int BC_W = $clog2(BUSY_CYCLES + 1);

  logic [BC_W-1:0]   left;
  logic              sweeping;
  logic [ADDR_W-1:0] sweep_addr;
  logic [DATA_W-1:0] word;

  assign we      = (start && !all) || sweeping;
  assign waddr   = start ? addr : sweep_addr;
  assign wdata_o = start ? wdata : word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      left       <= '0;
      sweeping   <= 1'b0;
      sweep_addr <= '0;
      word       <= '0;
    end else if (start) begin
      busy       <= 1'b1;
      left       <= BC_W'(BUSY_CYCLES - 1);
      word       <= wdata;
      sweeping   <= all;
      sweep_addr <= '0;
    end else begin
      if (busy) begin
        if (left == '0) busy <= 1'b0;
        else            left <= left - 1'b1;
      end
      if (sweeping) begin
        if (sweep_addr == '1) sweeping <= 1'b0;
        sweep_addr <= sweep_addr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic cs_q, sck_q, sdi_q, sck_prev, rise;
  logic wen_latch, rd_go, prog_start, start_all, busy, mem_we;
  logic rd_load, reading, status;
  logic [ADDR_W-1:0] addr_now, op_addr, mem_waddr;
  logic [DATA_W-1:0] word_now, mem_wdata, rdata;
  logic [DATA_W:0]   out_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      sdi_q    <= 1'b0;
      sck_prev <= 1'b0;
    end else begin
      cs_q     <= cs_i;
      sck_q    <= sck_i;
      sdi_q    <= sdi_i;
      sck_prev <= sck_q;
    end
  end

  assign rise = sck_q && !sck_prev;

  eep3w_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .sel(cs_q), .rise(rise), .sdi(sdi_q),
    .enable(!busy), .wen(wen_latch), .rd_go(rd_go), .commit(prog_start),
    .commit_all(start_all), .addr_now(addr_now), .op_addr(op_addr),
    .word_now(word_now)
  );

  eep3w_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start(prog_start), .all(start_all), .addr(op_addr),
    .wdata(word_now), .busy(busy), .we(mem_we), .waddr(mem_waddr),
    .wdata_o(mem_wdata)
  );

  eep3w_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(addr_now), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_load  <= 1'b0;
      reading  <= 1'b0;
      out_sh   <= '0;
      status   <= 1'b0;
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      rd_load <= rd_go;
      if (!cs_q) begin
        reading <= 1'b0;
        out_sh  <= '0;
      end else if (rd_go) begin
        reading <= 1'b1;
        out_sh  <= '0;
      end else if (rd_load) begin
        out_sh <= {1'b0, rdata};
      end else if (reading && rise) begin
        out_sh <= {out_sh[DATA_W-1:0], 1'b0};
      end
      if (prog_start)         status <= 1'b1;
      else if (!cs_q && !busy) status <= 1'b0;
      sdo_oe_o <= cs_q;
      sdo_o    <= cs_q && (status ? !busy : out_sh[DATA_W]);
    end
  end
endmodule

// File: rtl/eep3w_slave_chk.sv
module eep3w_slave_chk #(
  parameter int BUSY_CYCLES = 1000
) (
  input logic clk,
  input logic rst,
  input logic cs_i,
  input logic sdo_oe_o,
  input logic busy,
  input logic prog_start,
  input logic mem_we,
  input logic wen_latch
);
  int unsigned age;
  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= 0;
      busy_len <= 0;
    end else begin
      if (age < 3) age <= age + 1;
      busy_len <= busy ? busy_len + 1 : 0;
    end
  end

  AST_OE_TRACKS_CS: assert property (@(posedge clk) disable iff (rst)
    (age >= 2) |-> (sdo_oe_o == $past(cs_i, 2))); // R13
  AST_WE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wen_latch); // R2
  AST_NO_START_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !prog_start); // R10
  AST_START_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> busy); // R7
  AST_WE_IN_PROG: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy || prog_start)); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ((age >= 1) && $fell(busy)) |-> (busy_len == BUSY_CYCLES)); // R11
endmodule

bind eep3w_slave eep3w_slave_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_i(cs_i), .sdo_oe_o(sdo_oe_o), .busy(busy),
  .prog_start(prog_start), .mem_we(mem_we), .wen_latch(wen_latch)
);

// File: tb/eep3w_slave_test.sv
module eep3w_slave_test;
  localparam int BUSY = 1000;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eep3w_slave #(.ADDR_W(8), .DATA_W(16), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    cs = 0; sck = 0; sdi = 0;
    rst = 1; waitc(4);
    rst = 0; waitc(4);
  endtask

  task automatic sbit(input logic b);
    sdi = b; waitc(HALF);
    sck = 1; waitc(HALF);
    sck = 0;
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a,
                      input logic [15:0] d, input int nbits);
    logic [26:0] f;
    f = {1'b1, op, a, d};
    cs = 1; waitc(HALF);
    for (int i = 0; i < nbits; i++) sbit(f[26-i]);
    waitc(HALF);
    cs = 0; waitc(2*HALF);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d, input string req);
    logic [10:0] h;
    h = {1'b1, 2'b10, a};
    cs = 1; waitc(HALF);
    for (int i = 0; i < 11; i++) sbit(h[10-i]);
    chk({req, " dummy"}, {30'd0, sdo_oe, sdo}, 32'h2);
    for (int i = 0; i < 16; i++) begin
      sbit(1'b0);
      d[15-i] = sdo;
    end
    cs = 0; waitc(2*HALF);
  endtask

  task automatic ready_cycle(input string req);
    cs = 1; waitc(4);
    chk({req, " busy"}, {31'd0, sdo}, 32'd0);
    waitc(BUSY + 50);
    chk({req, " ready"}, {31'd0, sdo}, 32'd1);
    cs = 0; waitc(2*HALF);
  endtask

  task automatic t_reset();
    chk("R13 oe after reset", {31'd0, sdo_oe}, 32'd0);
    chk("R2 sdo after reset", {31'd0, sdo}, 32'd0);
    cs = 1; waitc(4);
    chk("R13 oe follows cs", {30'd0, sdo_oe, sdo}, 32'h2);
    cs = 0; waitc(4);
    chk("R13 oe low", {31'd0, sdo_oe}, 32'd0);
  endtask

  task automatic t_fill();
    logic [15:0] d;
    send(2'b00, 8'hC0, 16'h0, 27);
    send(2'b00, 8'h40, 16'h1234, 27);
    ready_cycle("R11 fill");
    rd(8'h00, d, "R8"); chk("R8 addr 00", d, 16'h1234);
    rd(8'h80, d, "R8"); chk("R8 addr 80", d, 16'h1234);
    rd(8'hFF, d, "R1"); chk("R1 addr FF", d, 16'h1234);
  endtask

  task automatic t_write();
    logic [15:0] d;
    send(2'b01, 8'h05, 16'hBEEF, 27);
    ready_cycle("R11 write");
    send(2'b01, 8'h06, 16'h0F0F, 27);
    ready_cycle("R12 second write");
    rd(8'h05, d, "R5"); chk("R5 write 05", d, 16'hBEEF);
    rd(8'h06, d, "R12"); chk("R12 write 06", d, 16'h0F0F);
  endtask

  task automatic t_cancel();
    logic [15:0] d;
    send(2'b01, 8'h07, 16'hFFFF, 26);
    rd(8'h07, d, "R6"); chk("R6 cancelled write", d, 16'h1234);
  endtask

  task automatic t_commit_edge();
    logic [15:0] d;
    send(2'b01, 8'h07, 16'hAAAA, 27);
    ready_cycle("R7");
    rd(8'h07, d, "R7"); chk("R7 committed write", d, 16'hAAAA);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] d;
    send(2'b01, 8'h08, 16'h5555, 27);
    send(2'b01, 8'h0A, 16'h7777, 27);
    ready_cycle("R10");
    rd(8'h08, d, "R10"); chk("R10 first write", d, 16'h5555);
    rd(8'h0A, d, "R10"); chk("R10 ignored write", d, 16'h1234);
  endtask

  task automatic t_guard();
    logic [15:0] d;
    send(2'b00, 8'h00, 16'h0, 27);
    send(2'b01, 8'h05, 16'h0000, 27);
    rd(8'h05, d, "R4"); chk("R3 R4 write after disable", d, 16'hBEEF);
    send(2'b00, 8'hC0, 16'h0, 8);
    send(2'b01, 8'h05, 16'h0000, 27);
    rd(8'h05, d, "R3"); chk("R3 partial enable", d, 16'hBEEF);
  endtask

  task automatic t_read_cancel();
    logic [15:0] d;
    send(2'b10, 8'h06, 16'h0, 15);
    chk("R9 oe after cancel", {31'd0, sdo_oe}, 32'd0);
    rd(8'h06, d, "R9"); chk("R9 read after cancel", d, 16'h0F0F);
  endtask

  task automatic t_reset_clears();
    logic [15:0] d;
    send(2'b00, 8'hC0, 16'h0, 27);
    do_reset();
    send(2'b01, 8'h05, 16'h1111, 27);
    rd(8'h05, d, "R2"); chk("R2 write after reset", d, 16'hBEEF);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_fill();
    t_write();
    t_cancel();
    t_commit_edge();
    t_busy_ignore();
    t_guard();
    t_read_cancel();
    t_reset_clears();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule